// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Engine

This block moves audio samples between system memory and two codec interfaces. Each interface has a playback channel and a capture channel, which gives four channels. A playback channel reads memory and hands words to its codec. A capture channel collects words from its codec and writes them to memory. Each channel walks a ring buffer defined by a base address and a byte length. Every memory access moves one 32-byte line. Each channel has a two-line staging FIFO between the memory port and the codec word port.

Two sticky status bits per channel mark when the buffer is half consumed and when it is fully consumed. Software can therefore refill one half of the buffer while the other half is in use. When the buffer ends, the offset returns to zero by itself, so the same ring repeats with no reprogramming. A bridge reset input halts all traffic and clears every channel. The memory side is a single request/grant port, and it carries a whole line in the cycle of the grant.

Top module: `audio_ring_dma`

## Requirements
- R1: After rst_n is low, or while brg_rst is high, the block is quiet. irq_stat reads 0, mem_req is 0, tx_avail is 00 and rx_room is 11. Every channel is inactive, and a cfg write made while brg_rst is high is ignored.
- R2: Channels are numbered as follows: 0 is interface 0 playback, 1 is interface 0 capture, 2 is interface 1 playback and 3 is interface 1 capture. A cfg write with a nonzero length (a multiple of 64) starts that channel at offset 0. A cfg write with length 0 stops the channel, so it makes no further memory requests.
- R3: An active playback channel requests a memory read (mem_we=0) at address base+offset while its FIFO holds fewer than two lines. The granted line is loaded into the FIFO.
- R4: An active capture channel requests a memory write (mem_we=1) while its FIFO holds a full line. A line is filled by eight rx_push words, and the k-th pushed word appears at mem_wdata[32k+31:32k]. rx_room drops to 0 once two lines are full.
- R5: Playback words leave through tx_word in order, starting with the lowest 32 bits of each line. tx_avail is high while a line is held. The FIFO holds at most two lines, and no further read is requested until eight pops free a line.
- R6: Each granted burst advances the channel offset by 32. The burst that brings the offset to the length returns the offset to 0, so the next address is the base again.
- R7: Status bit 2c is set by the burst on channel c that brings the transferred count to half the length, rounded down to a multiple of 32. Status bit 2c+1 is set by the burst that completes the length.
- R8: Status bits stay set until a 1 is written to the matching irq_clr bit. irq is high when any status bit is set together with its irq_en bit.
- R9: When several channels request in the same cycle, the memory port serves them round robin in the order 0,1,2,3, starting after the channel granted last. After reset, channel 0 has first turn.
- R10: mon_cnt shows the running byte offset of the channel selected by mon_ch.
- R11: While mem_gnt is low, a pending request keeps its address and no channel state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| brg_rst | input | 1 | Bridge reset: halts and clears all channels |
| cfg_we | input | 1 | Channel setup strobe |
| cfg_ch | input | 2 | Channel being set up |
| cfg_base | input | AW | Ring base address |
| cfg_len | input | CW | Ring length in bytes (0 stops the channel) |
| irq_en | input | 8 | Enables for the status bits |
| irq_clr | input | 8 | Write-1-to-clear for the status bits |
| irq_stat | output | 8 | Sticky status: bit 2c half, bit 2c+1 full |
| irq | output | 1 | Interrupt request |
| mon_ch | input | 2 | Channel shown on mon_cnt |
| mon_cnt | output | CW | Running byte offset of the selected channel |
| mem_req | output | 1 | Memory line request |
| mem_gnt | input | 1 | Grant; the line moves in this cycle |
| mem_we | output | 1 | 1 = write line, 0 = read line |
| mem_addr | output | AW | Line address |
| mem_wdata | output | BB*8 | Line written to memory |
| mem_rdata | input | BB*8 | Line read from memory |
| tx_pop | input | 2 | Playback word taken, per interface |
| tx_avail | output | 2 | Playback word present, per interface |
| tx_word | output | 2*WW | Playback word, per interface |
| rx_push | input | 2 | Capture word offered, per interface |
| rx_word | input | 2*WW | Capture word, per interface |
| rx_room | output | 2 | Capture FIFO can accept a word, per interface |

## Verification
The hardest cases to reach are the ring wrap and the half and full status events on a playback channel. The channel stops requesting once its two FIFO lines are full, so the offset only reaches the end of the buffer if the codec side keeps draining. The stimulus alternates eight pops with one grant until the offset passes half and then full length. It checks the address that follows the wrap and the order of the words popped. Contention is forced by starting two playback channels while the grant is held low, so the round-robin order shows up in the sequence of addresses.

// File: rtl/audio_ring_dma.sv
`timescale 1ns/1ps
module audio_ring_dma #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int WW = 32,
  parameter int BB = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brg_rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_ch,
  input  logic [AW-1:0]    cfg_base,
  input  logic [CW-1:0]    cfg_len,
  input  logic [7:0]       irq_en,
  input  logic [7:0]       irq_clr,
  output logic [7:0]       irq_stat,
  output logic             irq,
  input  logic [1:0]       mon_ch,
  output logic [CW-1:0]    mon_cnt,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [BB*8-1:0]  mem_wdata,
  input  logic [BB*8-1:0]  mem_rdata,
  input  logic [1:0]       tx_pop,
  output logic [1:0]       tx_avail,
  output logic [2*WW-1:0]  tx_word,
  input  logic [1:0]       rx_push,
  input  logic [2*WW-1:0]  rx_word,
  output logic [1:0]       rx_room
);
  localparam int LW = BB * 8;
  localparam int NW = LW / WW;
  localparam int XW = $clog2(NW);
  localparam int NC = 4;

  logic [AW-1:0] base [NC];
  logic [CW-1:0] len  [NC];
  logic [CW-1:0] off  [NC];
  logic [CW-1:0] nxt  [NC];
  logic [CW-1:0] half [NC];
  logic [LW-1:0] st   [NC][2];
  logic [1:0]    cnt  [NC];
  logic [XW-1:0] widx [NC];
  logic [NC-1:0] act, wp, rp, req, ev, wl, xfer, inc, dec;
  logic [7:0]    setv;
  logic [1:0]    lg, sel;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      nxt[c]  = off[c] + CW'(BB);
      half[c] = (len[c] >> 1) & ~CW'(BB - 1);
      ev[c]   = (c % 2 == 1) ? (rx_push[c/2] && rx_room[c/2]) : (tx_pop[c/2] && tx_avail[c/2]);
      wl[c]   = ev[c] && (widx[c] == XW'(NW - 1));
      req[c]  = !brg_rst && act[c] && ((c % 2 == 1) ? (cnt[c] != 2'd0) : (cnt[c] != 2'd2));
    end
  end

  always_comb begin
    logic f;
    logic [1:0] idx;
    f   = 1'b0;
    sel = lg;
    for (int k = 1; k <= NC; k++) begin
      idx = lg + 2'(k);
      if (!f && req[idx]) begin
        sel = idx;
        f   = 1'b1;
      end
    end
  end

  assign mem_req   = |req;
  assign xfer      = (mem_req && mem_gnt) ? (NC'(1) << sel) : '0;
  assign mem_we    = sel[0];
  assign mem_addr  = base[sel] + AW'(off[sel]);
  assign mem_wdata = st[sel][rp[sel]];
  assign irq       = |(irq_stat & irq_en);
  assign mon_cnt   = off[mon_ch];

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      inc[c]        = (c % 2 == 1) ? wl[c] : xfer[c];
      dec[c]        = (c % 2 == 1) ? xfer[c] : wl[c];
      setv[2*c]     = xfer[c] && (nxt[c] == half[c]);
      setv[2*c+1]   = xfer[c] && (nxt[c] == len[c]);
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_if
    assign tx_avail[i]        = cnt[2*i] != 2'd0;
    assign rx_room[i]         = cnt[2*i+1] != 2'd2;
    assign tx_word[i*WW +: WW] = st[2*i][rp[2*i]][widx[2*i]*WW +: WW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lg <= 2'd3; irq_stat <= '0; act <= '0; wp <= '0; rp <= '0;
      for (int c = 0; c < NC; c++) begin
        base[c] <= '0; len[c] <= '0; off[c] <= '0; cnt[c] <= '0; widx[c] <= '0;
      end
    end else if (brg_rst) begin
      lg <= 2'd3; irq_stat <= '0; act <= '0; wp <= '0; rp <= '0;
      for (int c = 0; c < NC; c++) begin
        base[c] <= '0; len[c] <= '0; off[c] <= '0; cnt[c] <= '0; widx[c] <= '0;
      end
    end else begin
      if (mem_req && mem_gnt) lg <= sel;
      irq_stat <= (irq_stat & ~irq_clr) | setv;
      for (int c = 0; c < NC; c++) begin
        if (ev[c]) widx[c] <= widx[c] + 1'b1;
        if (ev[c] && c % 2 == 1) st[c][wp[c]][widx[c]*WW +: WW] <= rx_word[(c/2)*WW +: WW];
        if (xfer[c] && c % 2 == 0) st[c][wp[c]] <= mem_rdata;
        if (inc[c]) wp[c] <= ~wp[c];
        if (dec[c]) rp[c] <= ~rp[c];
        cnt[c] <= cnt[c] + {1'b0, inc[c]} - {1'b0, dec[c]};
        if (xfer[c]) off[c] <= (nxt[c] == len[c]) ? '0 : nxt[c];
        if (cfg_we && cfg_ch == 2'(c)) begin
          base[c] <= cfg_base;
          len[c]  <= cfg_len;
          off[c]  <= '0;
          act[c]  <= cfg_len != '0;
        end
      end
    end
  end
endmodule

// File: rtl/audio_ring_dma_chk.sv
`timescale 1ns/1ps
module audio_ring_dma_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brg_rst,
  input logic [7:0] irq_clr,
  input logic [7:0] irq_stat,
  input logic       mem_req,
  input logic       mem_gnt,
  input logic       mem_we,
  input logic [1:0] sel,
  input logic [1:0] tx_pop,
  input logic [1:0] tx_avail,
  input logic [1:0] rx_room
);
  assert_halt_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    brg_rst |=> (irq_stat == 8'd0 && tx_avail == 2'b00 && rx_room == 2'b11));

  assert_halt_noreq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    brg_rst |-> !mem_req);

  assert_sticky_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(brg_rst) |-> ((($past(irq_stat) & ~$past(irq_clr)) & ~irq_stat) == 8'd0));

  assert_read_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && !mem_we) |=> tx_avail[$past(sel[1])]);

  assert_write_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && mem_we) |=> rx_room[$past(sel[1])]);

  assert_avail_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(brg_rst) |-> ((($past(tx_avail) & ~$past(tx_pop)) & ~tx_avail) == 2'b00));
endmodule

bind audio_ring_dma audio_ring_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .brg_rst(brg_rst), .irq_clr(irq_clr), .irq_stat(irq_stat),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .sel(sel),
  .tx_pop(tx_pop), .tx_avail(tx_avail), .rx_room(rx_room)
);

// File: tb/sim_audio_ring_dma.sv
`timescale 1ns/1ps
module sim_audio_ring_dma;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, brg_rst, cfg_we, irq, mem_req, mem_gnt, mem_we;
  logic [1:0] cfg_ch, mon_ch, tx_pop, tx_avail, rx_push, rx_room;
  logic [31:0] cfg_base, mem_addr;
  logic [15:0] cfg_len, mon_cnt;
  logic [7:0] irq_en, irq_clr, irq_stat;
  logic [255:0] mem_wdata, mem_rdata;
  logic [63:0] tx_word, rx_word;

  audio_ring_dma u0 (.*);

  always_comb
    for (int k = 0; k < 8; k++) mem_rdata[k*32 +: 32] = mem_addr + 32'(k);

  int total = 0, bad = 0;

  task automatic chk(string r, logic [63:0] a, logic [63:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, a, e);
    end
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic cfg(logic [1:0] ch, logic [31:0] b, logic [15:0] l);
    cfg_ch = ch; cfg_base = b; cfg_len = l; cfg_we = 1'b1; step; cfg_we = 1'b0;
  endtask

  task automatic grant; mem_gnt = 1'b1; step; mem_gnt = 1'b0; endtask

  task automatic pop8(int i, logic [31:0] first);
    for (int k = 0; k < 8; k++) begin
      chk("R5 tx word order", tx_word[i*32 +: 32], first + 32'(k));
      tx_pop[i] = 1'b1; step; tx_pop[i] = 1'b0;
    end
  endtask

  task automatic push8(int i, logic [31:0] first);
    for (int k = 0; k < 8; k++) begin
      rx_word[i*32 +: 32] = first + 32'(k); rx_push[i] = 1'b1; step; rx_push[i] = 1'b0;
    end
  endtask

  task automatic bridge_reset; brg_rst = 1'b1; step; brg_rst = 1'b0; step; endtask

  task automatic t_reset;
    chk("R1 status", irq_stat, 0);
    chk("R1 req", mem_req, 0);
    chk("R1 tx_avail", tx_avail, 0);
    chk("R1 rx_room", rx_room, 2'b11);
    chk("R10 mon_cnt", mon_cnt, 0);
  endtask

  task automatic t_tx;
    mon_ch = 2'd0;
    cfg(2'd0, 32'h1000, 16'd128);
    chk("R3 req", mem_req, 1); chk("R3 read", mem_we, 0); chk("R3 addr", mem_addr, 32'h1000);
    step;
    chk("R11 addr held", mem_addr, 32'h1000); chk("R11 no fill", tx_avail, 0); chk("R11 off", mon_cnt, 0);
    grant;
    chk("R10 off 32", mon_cnt, 32); chk("R5 avail", tx_avail[0], 1);
    chk("R6 next addr", mem_addr, 32'h1020); chk("R7 no status", irq_stat, 0);
    grant;
    chk("R7 half", irq_stat, 8'h01); chk("R5 full stops req", mem_req, 0);
    pop8(0, 32'h1000);
    chk("R5 req after pops", mem_req, 1); chk("R6 addr", mem_addr, 32'h1040);
    grant;
    chk("R5 full again", mem_req, 0);
    pop8(0, 32'h1020);
    grant;
    chk("R6 wrap off", mon_cnt, 0); chk("R7 full", irq_stat, 8'h03);
    pop8(0, 32'h1040);
    chk("R6 wrap addr", mem_addr, 32'h1000); chk("R6 wrap req", mem_req, 1);
    irq_en = 8'h00; step; chk("R8 masked", irq, 0);
    irq_en = 8'h01; step; chk("R8 enabled", irq, 1);
    irq_clr = 8'h01; step; irq_clr = 8'h00;
    chk("R8 clear one", irq_stat, 8'h02); chk("R8 irq off", irq, 0);
    step; chk("R8 sticky", irq_stat, 8'h02);
    cfg(2'd0, 32'h1000, 16'd0);
    chk("R2 stop", mem_req, 0);
  endtask

  task automatic t_brg;
    brg_rst = 1'b1; cfg_ch = 2'd0; cfg_base = 32'h5000; cfg_len = 16'd64; cfg_we = 1'b1;
    step; cfg_we = 1'b0;
    chk("R1 halt status", irq_stat, 0); chk("R1 halt avail", tx_avail, 0); chk("R1 halt req", mem_req, 0);
    brg_rst = 1'b0; step;
    chk("R1 write ignored", mem_req, 0);
  endtask

  task automatic t_rx;
    mon_ch = 2'd1;
    cfg(2'd1, 32'h2000, 16'd64);
    chk("R4 empty no req", mem_req, 0); chk("R4 room", rx_room[0], 1);
    push8(0, 32'hA0);
    chk("R4 req", mem_req, 1); chk("R4 write", mem_we, 1); chk("R4 addr", mem_addr, 32'h2000);
    for (int k = 0; k < 8; k++) chk("R4 wdata", mem_wdata[k*32 +: 32], 32'hA0 + 32'(k));
    push8(0, 32'hB0);
    chk("R4 no room", rx_room[0], 0);
    grant;
    chk("R7 rx half", irq_stat, 8'h04); chk("R10 rx off", mon_cnt, 32);
    chk("R4 room back", rx_room[0], 1); chk("R6 rx addr", mem_addr, 32'h2020);
    for (int k = 0; k < 8; k++) chk("R4 wdata 2", mem_wdata[k*32 +: 32], 32'hB0 + 32'(k));
    grant;
    chk("R7 rx full", irq_stat, 8'h0C); chk("R6 rx wrap", mon_cnt, 0); chk("R4 drained", mem_req, 0);
    bridge_reset;
  endtask

  task automatic t_rr;
    cfg(2'd0, 32'h3000, 16'd256);
    cfg(2'd2, 32'h4000, 16'd256);
    chk("R9 first ch0", mem_addr, 32'h3000); grant;
    chk("R9 then ch2", mem_addr, 32'h4000); grant;
    chk("R9 back ch0", mem_addr, 32'h3020); grant;
    chk("R9 then ch2 again", mem_addr, 32'h4020); grant;
    chk("R9 both full", mem_req, 0);
    chk("R5 if1 word", tx_word[63:32], 32'h4000);
    chk("R5 if0 word", tx_word[31:0], 32'h3000);
  endtask

  initial begin
    rst_n = 0; brg_rst = 0; cfg_we = 0; cfg_ch = 0; cfg_base = 0; cfg_len = 0;
    irq_en = 0; irq_clr = 0; mon_ch = 0; mem_gnt = 0; tx_pop = 0; rx_push = 0; rx_word = 0;
    step; step; rst_n = 1; step;
    t_reset;
    t_tx;
    t_brg;
    t_rx;
    t_rr;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule